// File: doc/BRIEF.md
# Flash Chip-Erase Command Decoder

This block is the device-side command logic of a behavioural NOR-style flash model. It watches host write cycles (address, data and a write strobe) and recognises the keyed six-cycle chip-erase sequence. Once the last cycle is accepted, an internal erase engine runs by itself. It first clears every word of a small on-chip array to zero and checks each one. It then waits out a parameterised erase time and sets the whole array to all ones.

While the engine runs, the ready output is low. Reads return status bits instead of array data: a polling bit held at 0, and two toggle bits that flip on every read. Writes made during that time are dropped. A hardware reset stops the engine at once. Words already cleared stay cleared, and the host has to send the whole sequence again. When the erase ends, reads go straight back to array data.

Top module: `flash_erase_ctrl`

## Requirements
- R1: The erase starts only after six consecutive write cycles, as (address/data, hex): 555/AA, 2AA/55, 555/80, 555/AA, 2AA/55, 555/10. `ready` goes low in the cycle after the sixth write is sampled.
- R2: A write cycle whose address or data differs from the expected one returns the decoder to its first step. Cycles already accepted are discarded, so no erase follows unless a full new sequence is sent.
- R3: The busy period lasts exactly 2*DEPTH + ERASE_CYCLES clock cycles, counted from the edge that samples the sixth write. `ready` is high again on the edge that ends it.
- R4: In the k-th busy cycle (k = 1..DEPTH), the engine clears array word k-1 to 0x00. It then spends DEPTH cycles checking that each word reads zero.
- R5: When the erase completes, every array word reads 0xFF, and reads return array data again. In particular, bit 7 shows the data.
- R6: Write cycles made while busy are ignored. They do not lengthen the busy period and do not advance the decoder.
- R7: A read while busy returns bit 7 = 0. Bits 6 and 2 both equal a toggle state, and all other bits are 0. The toggle state is 0 at the start of each erase and inverts after every busy read.
- R8: A low `rst_n` sampled on an edge aborts the erase and clears the decoder, so `ready` is high after that edge. Words already cleared stay 0x00, and words not yet reached keep their value. A reset on the same edge as the sixth write prevents the erase.
- R9: After reset with no erase run, `ready` is high. Reading address i (its low log2(DEPTH) bits select the word) returns the power-up content (i*59 + 18) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| bus_addr | input | ADDR_W | Host address for reads and writes |
| bus_wdata | input | 8 | Host write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Array data or erase status |
| ready | output | 1 | High when idle, low while erasing |

## Verification
Two functions can land on the same clock edge. The first case is a hardware reset arriving together with the sixth command write. The bench drives `rst_n` low during the cycle that carries the final 555/10 write. It then judges that `ready` stays high and that a later complete sequence still starts an erase. The second case is a reset landing partway through the preprogram phase. There the array read-back must show cleared words exactly up to the aborted cycle and untouched words beyond it.

// File: rtl/flash_cmd_pkg.sv
// Shared constants, types and command tables for the chip-erase decoder.
// Assumes an 8-bit data bus and an address bus of at least 11 bits.
package flash_cmd_pkg;

    localparam int SEQ_LEN = 6;
    localparam int CMD_W   = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PREPROG,
        PH_VERIFY,
        PH_ERASE
    } phase_t;

    // Expected address for each step of the keyed sequence
    function automatic logic [10:0] step_addr(input logic [2:0] step);
        case (step)
            3'd1, 3'd4: step_addr = 11'h2AA;
            default:    step_addr = 11'h555;
        endcase
    endfunction

    // Expected data for each step of the keyed sequence
    function automatic logic [CMD_W-1:0] step_data(input logic [2:0] step);
        case (step)
            3'd0, 3'd3: step_data = 8'hAA;
            3'd1, 3'd4: step_data = 8'h55;
            3'd2:       step_data = 8'h80;
            3'd5:       step_data = 8'h10;
            default:    step_data = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/flash_unlock_seq.sv
// Sequence decoder: steps through the six keyed write cycles and pulses
// start_o on the final one. Writes seen while busy_i is high are dropped.
// Assumes one write per strobe cycle.
module flash_unlock_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CMD_W-1:0]  data_i,
    input  logic              busy_i,
    output logic              start_o
);

    logic [2:0] step;
    logic       hit;

    // Compare the current cycle against the expected step
    always_comb begin
        hit     = we_i && !busy_i
                  && (addr_i == ADDR_W'(step_addr(step)))
                  && (data_i == step_data(step));
        start_o = hit && (step == 3'(SEQ_LEN - 1));
    end

    // Advance on a match, fall back to the first step on anything else
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (we_i && !busy_i) begin
            if (hit && step != 3'(SEQ_LEN - 1)) step <= step + 3'd1;
            else                                 step <= '0;
        end
    end

    AST_BUSY_HOLDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> step == $past(step)); // R6

endmodule

// File: rtl/flash_erase_engine.sv
// Autonomous erase engine: clears each word to zero, checks each word,
// waits ERASE_CYCLES, then requests an all-ones fill. Reset aborts at once.
// Assumes DEPTH is a power of two and at least 2.
module flash_erase_engine
    import flash_cmd_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int ERASE_CYCLES = 40,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(ERASE_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output phase_t        phase_o,
    output logic [AW-1:0] idx_o,
    output logic          clr_we_o,
    output logic          fill_o
);

    phase_t        phase;
    logic [AW-1:0] idx;
    logic [CW-1:0] cnt;

    // Phase sequencing with word index and erase timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            idx   <= '0;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start_i) begin
                    phase <= PH_PREPROG;
                    idx   <= '0;
                end
                PH_PREPROG: begin
                    idx <= idx + 1'b1;
                    if (idx == AW'(DEPTH - 1)) begin
                        phase <= PH_VERIFY;
                        idx   <= '0;
                    end
                end
                PH_VERIFY: begin
                    idx <= idx + 1'b1;
                    if (idx == AW'(DEPTH - 1)) begin
                        phase <= PH_ERASE;
                        idx   <= '0;
                        cnt   <= '0;
                    end
                end
                default: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(ERASE_CYCLES - 1)) phase <= PH_IDLE;
                end
            endcase
        end
    end

    // Decode outputs from the phase register
    always_comb begin
        busy_o   = (phase != PH_IDLE);
        phase_o  = phase;
        idx_o    = idx;
        clr_we_o = (phase == PH_PREPROG);
        fill_o   = (phase == PH_ERASE) && (cnt == CW'(ERASE_CYCLES - 1));
    end

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o); // R1
    AST_ERASE_EXITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_ERASE |=> (phase == PH_ERASE || phase == PH_IDLE)); // R3
    AST_RESET_ABORTS: assert property (@(posedge clk)
        !rst_n |=> !busy_o); // R8

endmodule

// File: rtl/flash_status_read.sv
// Read-data multiplexer: array data when idle, poll/toggle status when busy.
// The toggle state resets to 0 whenever the engine is idle.
module flash_status_read
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             rd_i,
    input  logic [CMD_W-1:0] arr_data_i,
    output logic [CMD_W-1:0] rdata_o
);

    logic tgl;

    // Flip the toggle state on each busy read, clear it when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_i) tgl <= 1'b0;
        else if (rd_i)         tgl <= ~tgl;
    end

    // Choose status word or array word
    always_comb begin
        if (busy_i) rdata_o = {1'b0, tgl, 3'b000, tgl, 2'b00};
        else        rdata_o = arr_data_i;
    end

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i && rd_i |=> tgl != $past(tgl)); // R7
    AST_TOGGLE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> !tgl); // R7

endmodule

// File: rtl/flash_erase_ctrl.sv
// Top: chip-erase decoder, erase engine, status read path and a small
// behavioural array. The array is non-volatile: reset leaves it untouched.
// Assumes ADDR_W >= 11 and DEPTH a power of two.
module flash_erase_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DEPTH        = 16,
    parameter int ERASE_CYCLES = 40,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [7:0]        bus_rdata,
    output logic              ready
);

    logic          start;
    logic          busy;
    phase_t        phase;
    logic [AW-1:0] eng_idx;
    logic          clr_we;
    logic          fill;
    logic [7:0]    mem [DEPTH];
    logic [7:0]    rd_word;

    // Power-up array content
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 59 + 18) % 256);
    end

    flash_unlock_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .data_i  (bus_wdata),
        .busy_i  (busy),
        .start_o (start)
    );

    flash_erase_engine #(.DEPTH(DEPTH), .ERASE_CYCLES(ERASE_CYCLES)) eng_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .busy_o   (busy),
        .phase_o  (phase),
        .idx_o    (eng_idx),
        .clr_we_o (clr_we),
        .fill_o   (fill)
    );

    // Array updates: all-ones fill at erase end, zero write during preprogram
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (fill)                             mem[i] <= 8'hFF;
                else if (clr_we && eng_idx == AW'(i)) mem[i] <= 8'h00;
            end
        end
    end

    // Array read port for host reads
    always_comb rd_word = mem[bus_addr[AW-1:0]];

    flash_status_read stat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy),
        .rd_i       (bus_re),
        .arr_data_i (rd_word),
        .rdata_o    (bus_rdata)
    );

    // Ready/busy pin
    always_comb ready = !busy;

    AST_VERIFY_SEES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_VERIFY |-> mem[eng_idx] == 8'h00); // R4
    AST_DONE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(rst_n) |-> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF)); // R5

endmodule

// File: tb/flash_erase_ctrl_tb_top.sv
module flash_erase_ctrl_tb_top;

    localparam int ADDR_W = 11;
    localparam int DEPTH  = 16;
    localparam int EC     = 40;
    localparam int TOTAL  = 2 * DEPTH + EC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [7:0]        bus_rdata;
    logic              ready;

    int checks = 0;
    int errors = 0;

    flash_erase_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ERASE_CYCLES(EC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .ready     (ready)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 59 + 18) % 256);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_seq();
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
    endtask

    task automatic expect_array(input int zero_upto, input bit ones, input string tag);
        logic [7:0] d;
        logic [7:0] e;
        for (int i = 0; i < DEPTH; i++) begin
            rd(11'(i), d);
            if (i < zero_upto) e = 8'h00;
            else if (ones)     e = 8'hFF;
            else               e = pat(i);
            check(d == e, tag, d, e);
        end
    endtask

    task automatic t_reset_state();
        check(ready == 1'b1, "R9 ready after reset", ready, 1);
        expect_array(0, 1'b0, "R9 power-up content");
    endtask

    task automatic t_busy_window();
        send_seq();
        check(ready == 1'b0, "R1 busy after sixth write", ready, 0);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);   // R6: dropped while busy
        idle(TOTAL - 1 - 2);
        check(ready == 1'b0, "R3 still busy at last cycle", ready, 0);
        idle(1);
        check(ready == 1'b1, "R3 ready at end of window", ready, 1);
        expect_array(0, 1'b1, "R5 all ones after erase");
        wr(11'h555, 8'h80); wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
        check(ready == 1'b1, "R6 busy writes did not advance decoder", ready, 1);
    endtask

    task automatic t_status();
        logic [7:0] d;
        send_seq();
        rd(11'h000, d); check(d == 8'h00, "R7 first busy read", d, 8'h00);
        rd(11'h005, d); check(d == 8'h44, "R7 second busy read", d, 8'h44);
        rd(11'h000, d); check(d == 8'h00, "R7 third busy read", d, 8'h00);
        idle(TOTAL - 3);
        check(ready == 1'b1, "R3 ready after status erase", ready, 1);
        rd(11'h003, d); check(d == 8'hFF, "R5 poll bit shows data", d, 8'hFF);
    endtask

    task automatic t_mismatch();
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'h90); wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
        check(ready == 1'b1, "R2 bad data aborts sequence", ready, 1);
        wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
        check(ready == 1'b1, "R2 bad address aborts sequence", ready, 1);
        wr(11'h555, 8'hAA); wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
        check(ready == 1'b1, "R2 partial steps discarded", ready, 1);
    endtask

    task automatic t_abort();
        send_seq();
        idle(5);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(ready == 1'b1, "R8 reset aborts erase", ready, 1);
        expect_array(5, 1'b1, "R4 R8 partial preprogram kept");
    endtask

    task automatic t_reset_collision();
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
        rst_n = 1'b0;
        wr(11'h555, 8'h10);
        rst_n = 1'b1;
        check(ready == 1'b1, "R8 reset wins over sixth write", ready, 1);
        send_seq();
        check(ready == 1'b0, "R1 fresh sequence restarts erase", ready, 0);
        idle(TOTAL);
        check(ready == 1'b1, "R3 restarted erase completes", ready, 1);
        expect_array(0, 1'b1, "R5 all ones after restart");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset_state();
        t_busy_window();
        t_status();
        t_mismatch();
        t_abort();
        t_reset_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule